// File: doc/BRIEF.md
# Hour Ring Counter with Wrap Reset

This block keeps the hour of a clock as two one-hot rings: a ten-stage ring for the units digit and a three-stage ring for the tens digit. Each hour-advance pulse moves the units ring on by one stage. When the units ring passes from its last stage back to its first, the tens ring also moves on by one stage. Only one stage of each ring is active at any time, so the outputs can drive a digit or LED decoder directly.

A mode input selects how the count wraps. In 12-hour operation the count starts at 01 and goes up to 12. In 24-hour operation it starts at 00 and goes up to 23. The control logic watches for the pair of stages that make up the largest allowed hour. On the advance that would step past that hour, it loads the start value of the mode into both rings, blocks the carry that would otherwise reach the stage after the maximum, and raises a reset-event strobe for one cycle.

The mode is sampled only at a synchronous reset and at each wrap. Changing the mode input in the middle of the count has no effect until the next of those two events.

Top module: `hour_ring_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the rings are loaded with the start value of `mode_i`, and `wrap_o` is low afterwards. The start value is tens 0, units 1 when `mode_i`=0 (12-hour) and tens 0, units 0 when `mode_i`=1 (24-hour).
- R2: `units_o` and `tens_o` each have exactly one bit set at all times after reset. Bit k of `units_o` means units digit k, and bit k of `tens_o` means tens digit k. The tens ring never carries out of its last stage.
- R3: On an edge where `adv_i` is high and no wrap occurs, the units digit goes up by one. On an edge where `adv_i` is low, both outputs hold their values.
- R4: An advance taken with units digit 9 sets the units digit to 0 and raises the tens digit by one on the same edge.
- R5: In 12-hour operation, an advance taken at hour 12 (tens 1, units 2) sets the count to 01.
- R6: In 24-hour operation, an advance taken at hour 23 (tens 2, units 3) sets the count to 00.
- R7: `wrap_o` is high for exactly the one cycle after a wrapping edge, and it is high together with the new start value. The count never shows the hour after the maximum of the active mode.
- R8: The count and wrap behave correctly when `adv_i` is held high on every cycle.
- R9: A change of `mode_i` does not alter the current count or the maximum in use. It takes effect at the next wrap, which loads the start value of the new mode, or at the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv_i | input | 1 | Hour-advance request, one step per cycle while high |
| mode_i | input | 1 | 0 = 12-hour, 1 = 24-hour |
| units_o | output | 10 | One-hot units digit |
| tens_o | output | 3 | One-hot tens digit |
| wrap_o | output | 1 | One-cycle reset-event strobe |

## Verification
The assertions assume that `rst` is held high from time zero through at least one rising edge. Until then the rings hold no defined value. They also assume that `adv_i` and `mode_i` are synchronous to `clk`. The bench meets both conditions: it raises reset before the first edge and changes every input only on falling clock edges. For each requirement, the bench compares the outputs with a separate hour-and-mode model, using single pulses, gaps with no advance, unbroken runs of advances, and mode changes in the middle of the count.

// File: rtl/hr_pkg.sv
package hr_pkg;
    typedef enum logic {
        MODE_12H = 1'b0,
        MODE_24H = 1'b1
    } hr_mode_e;
endpackage

// File: rtl/hr_onehot_ring.sv
module hr_onehot_ring #(
    parameter int N  = 10,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [IW-1:0] load_idx_i,
    input  logic          step_i,
    output logic [N-1:0]  ring_o,
    output logic          carry_o
);
    typedef struct packed {
        logic [N-1:0] ring;
    } ring_state_t;

    ring_state_t  st_d, st_q;
    logic [N-1:0] load_vec;
    logic [N-1:0] rot_vec;

    for (genvar k = 0; k < N; k++) begin : g_dec
        assign load_vec[k] = (load_idx_i == IW'(k));
    end

    if (N > 1) begin : g_rot
        assign rot_vec = {st_q.ring[N-2:0], st_q.ring[N-1]};
    end else begin : g_rot1
        assign rot_vec = st_q.ring;
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.ring = load_vec;
        end else if (step_i) begin
            st_d.ring = rot_vec;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ring_o  = st_q.ring;
    assign carry_o = step_i & ~load_i & st_q.ring[N-1];

    // R2
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(ring_o) == 1);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!step_i && !load_i) |=> $stable(ring_o));

    // R3
    step_moves_chk: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (ring_o != $past(ring_o)));
endmodule

// File: rtl/hr_wrap_ctrl.sv
module hr_wrap_ctrl
    import hr_pkg::*;
#(
    parameter int UNITS_N = 10,
    parameter int TENS_N  = 3,
    parameter int MAX12   = 12,
    parameter int MAX24   = 23,
    parameter int START12 = 1,
    parameter int START24 = 0,
    parameter int UIW     = $clog2(UNITS_N),
    parameter int TIW     = $clog2(TENS_N)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_i,
    input  logic               mode_i,
    input  logic [UNITS_N-1:0] units_i,
    input  logic [TENS_N-1:0]  tens_i,
    output logic               load_o,
    output logic [UIW-1:0]     units_idx_o,
    output logic [TIW-1:0]     tens_idx_o,
    output logic               wrap_o
);
    localparam int M12_U = MAX12 % UNITS_N;
    localparam int M12_T = MAX12 / UNITS_N;
    localparam int M24_U = MAX24 % UNITS_N;
    localparam int M24_T = MAX24 / UNITS_N;
    localparam int S12_U = START12 % UNITS_N;
    localparam int S12_T = START12 / UNITS_N;
    localparam int S24_U = START24 % UNITS_N;
    localparam int S24_T = START24 / UNITS_N;
    localparam int P12_U = (MAX12 + 1) % UNITS_N;
    localparam int P12_T = (MAX12 + 1) / UNITS_N;

    typedef struct packed {
        hr_mode_e mode;
        logic     strobe;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    hr_mode_e    mode_in;
    logic        at_max;
    logic        wrap_evt;

    assign mode_in  = hr_mode_e'(mode_i);
    assign at_max   = (st_q.mode == MODE_24H) ? (tens_i[M24_T] & units_i[M24_U])
                                              : (tens_i[M12_T] & units_i[M12_U]);
    assign wrap_evt = adv_i & at_max;

    always_comb begin
        st_d        = st_q;
        st_d.strobe = 1'b0;
        if (rst) begin
            st_d.mode = mode_in;
        end else if (wrap_evt) begin
            st_d.mode   = mode_in;
            st_d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign load_o      = rst | wrap_evt;
    assign units_idx_o = (mode_in == MODE_24H) ? UIW'(S24_U) : UIW'(S12_U);
    assign tens_idx_o  = (mode_in == MODE_24H) ? TIW'(S24_T) : TIW'(S12_T);
    assign wrap_o      = st_q.strobe;

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> !wrap_o);

    // R5
    wrap12_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && st_q.mode == MODE_12H) |-> (units_i[S12_U] && tens_i[S12_T]));

    // R6
    wrap24_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && st_q.mode == MODE_24H) |-> (units_i[S24_U] && tens_i[S24_T]));

    // R7
    no_past_max12_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_12H) |-> !(tens_i[P12_T] && units_i[P12_U]));

    // R8
    adv_at_max_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_i && at_max) |=> wrap_o);
endmodule

// File: rtl/hour_ring_counter.sv
module hour_ring_counter #(
    parameter int UNITS_N = 10,
    parameter int TENS_N  = 3,
    parameter int MAX12   = 12,
    parameter int MAX24   = 23,
    parameter int START12 = 1,
    parameter int START24 = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv_i,
    input  logic               mode_i,
    output logic [UNITS_N-1:0] units_o,
    output logic [TENS_N-1:0]  tens_o,
    output logic               wrap_o
);
    localparam int UIW = $clog2(UNITS_N);
    localparam int TIW = $clog2(TENS_N);

    logic           load;
    logic [UIW-1:0] units_idx;
    logic [TIW-1:0] tens_idx;
    logic           units_carry;
    logic           tens_carry;

    hr_wrap_ctrl #(
        .UNITS_N(UNITS_N), .TENS_N(TENS_N), .MAX12(MAX12), .MAX24(MAX24),
        .START12(START12), .START24(START24), .UIW(UIW), .TIW(TIW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (adv_i),
        .mode_i     (mode_i),
        .units_i    (units_o),
        .tens_i     (tens_o),
        .load_o     (load),
        .units_idx_o(units_idx),
        .tens_idx_o (tens_idx),
        .wrap_o     (wrap_o)
    );

    hr_onehot_ring #(.N(UNITS_N), .IW(UIW)) u_units (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .load_idx_i(units_idx),
        .step_i    (adv_i),
        .ring_o    (units_o),
        .carry_o   (units_carry)
    );

    hr_onehot_ring #(.N(TENS_N), .IW(TIW)) u_tens (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load),
        .load_idx_i(tens_idx),
        .step_i    (units_carry),
        .ring_o    (tens_o),
        .carry_o   (tens_carry)
    );

    // R2
    tens_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !tens_carry);

    // R4
    carry_moves_tens_chk: assert property (@(posedge clk) disable iff (rst)
        (units_carry && !load) |=> (tens_o != $past(tens_o)));
endmodule

// File: tb/hour_ring_counter_bench.sv
`timescale 1ns/1ps
module hour_ring_counter_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       adv = 1'b0;
    logic       mode = 1'b0;
    logic [9:0] units;
    logic [2:0] tens;
    logic       wrap;

    int checks = 0;
    int errors = 0;
    int exp_hr;
    int act_mode;
    logic exp_wrap;

    always #5 clk = ~clk;

    hour_ring_counter u_hour_ring_counter (
        .clk(clk), .rst(rst), .adv_i(adv), .mode_i(mode),
        .units_o(units), .tens_o(tens), .wrap_o(wrap)
    );

    task automatic check(input string req);
        logic [9:0] eu;
        logic [2:0] et;
        eu = 10'(1) << (exp_hr % 10);
        et = 3'(1) << (exp_hr / 10);
        checks++;
        if (units !== eu || tens !== et || wrap !== exp_wrap) begin
            errors++;
            $display("FAIL %s: units=%b tens=%b wrap=%b expected units=%b tens=%b wrap=%b",
                     req, units, tens, wrap, eu, et, exp_wrap);
        end
    endtask

    task automatic model_step();
        int mx;
        mx = (act_mode == 1) ? 23 : 12;
        if (exp_hr == mx) begin
            act_mode = int'(mode);
            exp_hr   = (act_mode == 1) ? 0 : 1;
            exp_wrap = 1'b1;
        end else begin
            exp_hr++;
            exp_wrap = 1'b0;
        end
    endtask

    task automatic do_reset(input logic m, input string req);
        @(negedge clk);
        rst  = 1'b1;
        mode = m;
        @(negedge clk);
        rst      = 1'b0;
        act_mode = int'(m);
        exp_hr   = m ? 0 : 1;
        exp_wrap = 1'b0;
        check(req);
    endtask

    task automatic run_adv(input int n, input string req);
        adv = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            model_step();
            check(req);
        end
        adv = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            exp_wrap = 1'b0;
            check(req);
        end
    endtask

    task automatic t_reset();
        do_reset(1'b0, "R1 12h start");
        do_reset(1'b1, "R1 24h start");
    endtask

    task automatic t_step_carry();
        do_reset(1'b1, "R1");
        idle(4, "R3 hold");
        for (int i = 0; i < 9; i++) begin
            run_adv(1, "R3 single step R2");
            idle(2, "R3 hold between");
        end
        run_adv(1, "R4 carry 9 to 10");
        run_adv(5, "R4 after carry R2");
    endtask

    task automatic t_wrap24();
        do_reset(1'b1, "R1");
        run_adv(23, "R3 to 23");
        idle(1, "R3");
        run_adv(1, "R6 23 to 00 with R7 strobe");
        idle(2, "R7 strobe one cycle");
    endtask

    task automatic t_wrap12();
        do_reset(1'b0, "R1");
        run_adv(11, "R3 to 12");
        run_adv(1, "R5 12 to 01 with R7 strobe");
        idle(1, "R7 strobe low");
    endtask

    task automatic t_fast();
        do_reset(1'b1, "R1");
        run_adv(60, "R8 continuous 24h");
        do_reset(1'b0, "R1");
        run_adv(30, "R8 continuous 12h");
        idle(1, "R8");
    endtask

    task automatic t_mode_change();
        do_reset(1'b1, "R1");
        run_adv(15, "R3");
        @(negedge clk);
        mode = 1'b0;
        exp_wrap = 1'b0;
        check("R9 mode change leaves count");
        run_adv(8, "R9 old max still in use");
        run_adv(1, "R9 wrap loads 12h start");
        run_adv(11, "R9 new mode counts");
        run_adv(1, "R9 R5 12h wrap");
        @(negedge clk);
        mode = 1'b1;
        exp_wrap = 1'b0;
        check("R9 switch back");
        run_adv(11, "R9 12h max still in use");
        run_adv(1, "R9 wrap loads 24h start");
        idle(1, "R9");
    endtask

    initial begin
        #500us;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_hr = 1; act_mode = 0; exp_wrap = 1'b0;
        repeat (2) @(negedge clk);
        t_reset();
        t_step_carry();
        t_wrap24();
        t_wrap12();
        t_fast();
        t_mode_change();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule